// File: doc/BRIEF.md
# SMBus Indexed Configuration Register Target

This block is a two-wire SMBus target that holds a small bank of 8-bit configuration and status bytes for a clock distribution device. A host reaches the bank with indexed block transfers. A write names a start index and a byte count, then streams the data. A read first sets the index with a short write phase. After a repeated start the target sends a count byte and then data taken from successive indices.

The 7-bit bus address is chosen from nine values by two three-level strap inputs. The bank holds 19 output-enable bits that drive the `out_en_o` port, a programmable read length, fixed identification bytes and live readbacks of mode and pin inputs. SCL and SDA are resynchronised to the local clock, which must keep running for the bus to work. The open-drain pad is reduced to an input level and a pull-low request.

Top module: `smb_cfg_target`

## Requirements
- R1: The strap codes are 2'b00 low, 2'b01 mid and 2'b10 high; 2'b11 counts as mid. The 8-bit write address for the pair {strap_hi_i, strap_lo_i} is: low/low D8, low/mid DA, low/high DE, mid/low C2, mid/mid C4, mid/high C6, high/low CA, high/mid CC, high/high CE. A read uses the same value with bit 0 set. Any other address gets a NACK, and the rest of that transaction has no effect.
- R2: A write is start, address+W, index N, count X, then X data bytes. The target ACKs each of these bytes and stores them at N, N+1 and onward.
- R3: Data bytes beyond the count X get a NACK and are not stored.
- R4: A read is start, address+W, index N, repeated start, address+R. The target first returns the count byte {3'b000, byte7[4:0]} and then the bytes from index N upward, one byte for each host ACK.
- R5: Once it has sent as many data bytes as the count byte stated, the target releases SDA, so any further byte reads as 0xFF.
- R6: Byte 0 reads {mode[1:0], en18, en17, en16, 2'b00, freq}. Only bits 5:3 are writable.
- R7: Byte 1 holds enables 7..0 and byte 2 holds enables 15..8, both with bit 7 as the highest enable. Every enable resets to 1 and drives out_en_o at its own position.
- R8: Byte 3 returns the live levels of oe_pin_i[7:0]. It is read-only.
- R9: Byte 5 reads 0x0F, byte 6 reads 0x78, and bytes 4 and 8 read 0x00. Indices 9 and above read 0x00. Writes to any of these bytes change nothing.
- R10: Byte 7 resets to 0x08. Only bits 4:0 are writable, and bits 7:5 read as 0.
- R11: A stop condition ends a transaction at any point and releases SDA. The target starts pulling SDA low only while SCL is low.
- R12: After reset SDA is released and out_en_o is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock; must run for the bus to work |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level seen at the pad |
| sda_i | input | 1 | Bus data level seen at the pad |
| sda_drive_low_o | output | 1 | Asks the pad to pull SDA low |
| strap_hi_i | input | 2 | Upper address strap, three-level code |
| strap_lo_i | input | 2 | Lower address strap, three-level code |
| pll_mode_i | input | 2 | Mode level returned in byte 0 bits 7:6 |
| freq_sel_i | input | 1 | Frequency select level returned in byte 0 bit 0 |
| oe_pin_i | input | 8 | Enable pin levels returned in byte 3 |
| out_en_o | output | 19 | Output enables held in bytes 0 to 2 |

## Verification
The hardest state to reach from the ports is the end of a read, where the count from byte 7 runs out while the host is still ACKing. The target must then let SDA float rather than keep serving register bytes. The bench gets there by reprogramming byte 7 to a short count and reading one byte more than that count. It also streams one byte beyond the write count, to show that the extra byte gets a NACK and is dropped.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;
  localparam int BYTE_W    = 8;
  localparam int IDX_W     = 8;
  localparam int CNT_W     = 5;
  localparam int NUM_EN    = 19;
  localparam int NUM_PIN   = 8;
  localparam int LAST_IDX  = 8;
  localparam logic [BYTE_W-1:0] DEV_ID  = 8'h78;
  localparam logic [3:0]        VEND_ID = 4'hF;
  localparam logic [3:0]        REV_ID  = 4'h0;
  localparam logic [CNT_W-1:0]  CNT_RST = 5'd8;

  typedef enum logic [2:0] {L_IDLE, L_RECV, L_RXEND, L_ACK, L_SEND, L_HACK} link_st_t;
  typedef enum logic [1:0] {PH_ADDR, PH_INDEX, PH_COUNT, PH_DATA} phase_t;

  // fold the unused code onto mid
  function automatic logic [1:0] tri_norm(input logic [1:0] c);
    return (c == 2'b11) ? 2'b01 : c;
  endfunction

  // strap pair to 7-bit bus address
  function automatic logic [6:0] strap_addr(input logic [1:0] hi, input logic [1:0] lo);
    logic [7:0] a;
    case ({tri_norm(hi), tri_norm(lo)})
      4'b0000: a = 8'hD8;
      4'b0001: a = 8'hDA;
      4'b0010: a = 8'hDE;
      4'b0100: a = 8'hC2;
      4'b0101: a = 8'hC4;
      4'b0110: a = 8'hC6;
      4'b1000: a = 8'hCA;
      4'b1001: a = 8'hCC;
      default: a = 8'hCE;
    endcase
    return a[7:1];
  endfunction
endpackage

// File: rtl/smbcfg_sync.sv
module smbcfg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '1;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/smbcfg_cond.sv
module smbcfg_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_evt = scl_s && scl_q && sda_q && !sda_s;
  assign stop_evt  = scl_s && scl_q && !sda_q && sda_s;
  assign scl_rise  = scl_s && !scl_q;
  assign scl_fall  = !scl_s && scl_q;
endmodule

// File: rtl/smbcfg_link.sv
module smbcfg_link
  import smbcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic [6:0]        own_addr,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_low,
  output logic              wr_stb,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic [IDX_W-1:0]  rd_idx
);
  link_st_t          st;
  phase_t            ph;
  logic [2:0]        bcnt;
  logic [BYTE_W-1:0] sh, tx;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] wr_left, rd_left;
  logic              ack_q, go_tx, host_ack, ack_dec;

  wire [BYTE_W-1:0] rx_byte  = {sh[6:0], sda_s};
  wire              byte_end = (st == L_RECV) && scl_rise && (bcnt == 3'd7);
  wire              match    = (rx_byte[7:1] == own_addr);
  wire              credit   = (wr_left != '0);
  wire [BYTE_W-1:0] cnt_byte = {{(BYTE_W-CNT_W){1'b0}}, cnt_val};

  always_comb begin
    case (ph)
      PH_ADDR: ack_dec = match;
      PH_DATA: ack_dec = credit;
      default: ack_dec = 1'b1;
    endcase
  end

  assign wr_stb  = byte_end && (ph == PH_DATA) && credit;
  assign wr_idx  = idx;
  assign wr_data = rx_byte;
  assign rd_idx  = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= L_IDLE; ph <= PH_ADDR; bcnt <= '0; sh <= '0; tx <= '0;
      idx <= '0; wr_left <= '0; rd_left <= '0;
      ack_q <= 1'b0; go_tx <= 1'b0; host_ack <= 1'b0; sda_low <= 1'b0;
    end else if (start_evt) begin
      st <= L_RECV; ph <= PH_ADDR; bcnt <= '0; sda_low <= 1'b0;
    end else if (stop_evt) begin
      st <= L_IDLE; sda_low <= 1'b0;
    end else begin
      case (st)
        L_RECV: if (scl_rise) begin
          sh   <= rx_byte;
          bcnt <= bcnt + 3'd1;
          if (bcnt == 3'd7) begin
            st    <= L_RXEND;
            ack_q <= ack_dec;
            go_tx <= 1'b0;
            case (ph)
              PH_ADDR:  begin go_tx <= rx_byte[0]; ph <= PH_INDEX; end
              PH_INDEX: begin idx <= rx_byte; ph <= PH_COUNT; end
              PH_COUNT: begin wr_left <= rx_byte; ph <= PH_DATA; end
              default: if (credit) begin
                idx     <= idx + 1'b1;
                wr_left <= wr_left - 1'b1;
              end
            endcase
          end
        end
        L_RXEND: if (scl_fall) begin
          sda_low <= ack_q;
          st      <= L_ACK;
        end
        L_ACK: if (scl_fall) begin
          if (!ack_q) begin
            sda_low <= 1'b0;
            st      <= L_IDLE;
          end else if (go_tx) begin
            tx      <= cnt_byte;
            rd_left <= cnt_byte;
            sda_low <= ~cnt_byte[7];
            bcnt    <= '0;
            st      <= L_SEND;
          end else begin
            sda_low <= 1'b0;
            st      <= L_RECV;
          end
        end
        L_SEND: if (scl_fall) begin
          if (bcnt == 3'd7) begin
            sda_low <= 1'b0;
            bcnt    <= '0;
            st      <= L_HACK;
          end else begin
            tx      <= {tx[6:0], 1'b0};
            sda_low <= ~tx[6];
            bcnt    <= bcnt + 3'd1;
          end
        end
        L_HACK: begin
          if (scl_rise) host_ack <= ~sda_s;
          if (scl_fall) begin
            if (host_ack) begin
              bcnt <= '0;
              st   <= L_SEND;
              if (rd_left != '0) begin
                tx      <= rd_data;
                sda_low <= ~rd_data[7];
                idx     <= idx + 1'b1;
                rd_left <= rd_left - 1'b1;
              end else begin
                tx      <= '1;
                sda_low <= 1'b0;
              end
            end else begin
              sda_low <= 1'b0;
              st      <= L_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smbcfg_regs.sv
module smbcfg_regs
  import smbcfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic [1:0]         pll_mode_i,
  input  logic               freq_sel_i,
  input  logic [NUM_PIN-1:0] oe_pin_i,
  output logic [BYTE_W-1:0]  rd_data,
  output logic [NUM_EN-1:0]  out_en,
  output logic [CNT_W-1:0]   cnt_val
);
  logic [NUM_EN-1:0] en_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '1;
      cnt_q <= CNT_RST;
    end else if (wr_stb) begin
      case (wr_idx)
        8'd0: en_q[18:16] <= wr_data[5:3];
        8'd1: en_q[7:0]   <= wr_data;
        8'd2: en_q[15:8]  <= wr_data;
        8'd7: cnt_q       <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_idx)
      8'd0: rd_data = {pll_mode_i, en_q[18:16], 2'b00, freq_sel_i};
      8'd1: rd_data = en_q[7:0];
      8'd2: rd_data = en_q[15:8];
      8'd3: rd_data = oe_pin_i;
      8'd5: rd_data = {REV_ID, VEND_ID};
      8'd6: rd_data = DEV_ID;
      8'd7: rd_data = {{(BYTE_W-CNT_W){1'b0}}, cnt_q};
      default: rd_data = '0;
    endcase
  end

  assign out_en  = en_q;
  assign cnt_val = cnt_q;
endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
  import smbcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_drive_low_o,
  input  logic [1:0]         strap_hi_i,
  input  logic [1:0]         strap_lo_i,
  input  logic [1:0]         pll_mode_i,
  input  logic               freq_sel_i,
  input  logic [NUM_PIN-1:0] oe_pin_i,
  output logic [NUM_EN-1:0]  out_en_o
);
  logic [1:0]        line_s;
  logic              scl_s, sda_s;
  logic              start_evt, stop_evt, scl_rise, scl_fall;
  logic              wr_stb;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [CNT_W-1:0]  cnt_val;
  logic [6:0]        own_addr;

  assign own_addr = strap_addr(strap_hi_i, strap_lo_i);

  smbcfg_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  smbcfg_cond i_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  smbcfg_link i_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .own_addr(own_addr), .cnt_val(cnt_val), .rd_data(rd_data),
    .sda_low(sda_drive_low_o), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx)
  );

  smbcfg_regs i_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .pll_mode_i(pll_mode_i),
    .freq_sel_i(freq_sel_i), .oe_pin_i(oe_pin_i), .rd_data(rd_data),
    .out_en(out_en_o), .cnt_val(cnt_val)
  );
endmodule

// File: rtl/smb_cfg_target_chk.sv
module smb_cfg_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        sda_drive_low_o,
  input logic        stop_evt,
  input logic        wr_stb,
  input logic [7:0]  wr_idx,
  input logic [7:0]  rd_idx,
  input logic [18:0] out_en_o,
  input logic [4:0]  cnt_val
);
  p_free_after_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_drive_low_o);

  p_pull_on_low_scl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low_o) |-> !scl_s);

  p_en_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(out_en_o));

  p_const_bytes_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !(wr_idx inside {8'd0, 8'd1, 8'd2, 8'd7})) |=> ($stable(out_en_o) && $stable(cnt_val)));

  p_byte0_only_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_idx == 8'd0) |=> (out_en_o[15:0] == $past(out_en_o[15:0])));

  p_index_steps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (rd_idx == $past(wr_idx) + 8'd1));
endmodule

bind smb_cfg_target smb_cfg_target_chk i_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_drive_low_o(sda_drive_low_o),
  .stop_evt(stop_evt), .wr_stb(wr_stb), .wr_idx(wr_idx), .rd_idx(rd_idx),
  .out_en_o(out_en_o), .cnt_val(cnt_val)
);

// File: tb/test_smb_cfg_target.sv
`timescale 1ns/1ps
module test_smb_cfg_target;
  localparam int Q = 8;
  localparam logic [7:0] ADR = 8'hD8;
  // {index, value written, value read back}
  localparam logic [23:0] VEC [0:13] = '{
    24'h00FFB9, 24'h000081, 24'h01A5A5, 24'h023C3C, 24'h03005A,
    24'h04FF00, 24'h05000F, 24'h060078, 24'h085500, 24'h097700,
    24'hC81200, 24'h01FFFF, 24'h02FFFF, 24'h0028A9};
  // write addresses for straps hi*3+lo (low, mid, high)
  localparam logic [7:0] SADR [0:8] = '{8'hD8, 8'hDA, 8'hDE, 8'hC2, 8'hC4, 8'hC6, 8'hCA, 8'hCC, 8'hCE};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, host_sda = 1'b1;
  logic [1:0] strap_hi = 2'b00, strap_lo = 2'b00;
  logic sda_drive_low;
  logic [18:0] out_en;
  logic sda_line;
  int total = 0, bad = 0;
  logic [7:0] rbuf [0:15];

  always #10 clk = ~clk;
  assign sda_line = host_sda & ~sda_drive_low;

  smb_cfg_target i_smb_cfg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_drive_low_o(sda_drive_low), .strap_hi_i(strap_hi), .strap_lo_i(strap_lo),
    .pll_mode_i(2'b10), .freq_sel_i(1'b1), .oe_pin_i(8'h5A), .out_en_o(out_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; wq(); scl = 1'b1; wq(); host_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wq(); scl = 1'b1; wq(); host_sda = 1'b1; wq();
  endtask

  task automatic bus_bit(input logic b, output logic r);
    host_sda = b; wq(); scl = 1'b1; wq(); r = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
    bus_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic get_byte(input logic ack_it, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, r);
      d[i] = r;
    end
    bus_bit(~ack_it, r);
  endtask

  // one-byte write transaction; returns ack of the data byte
  task automatic wr1(input logic [7:0] idx, input logic [7:0] val, output logic ak);
    logic a;
    bus_start(); put_byte(ADR, a); put_byte(idx, a); put_byte(8'd1, a);
    put_byte(val, ak); bus_stop();
  endtask

  // read: count byte into rbuf[0], then n further bytes
  task automatic rd(input logic [7:0] idx, input int n, output logic aaddr);
    logic a;
    bus_start(); put_byte(ADR, aaddr); put_byte(idx, a);
    bus_start(); put_byte(ADR | 8'h01, a);
    for (int i = 0; i <= n; i++) get_byte(i != n, rbuf[i]);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic a, a2;
    repeat (5) @(negedge clk);
    // R12 reset state
    chk("R12 out_en after reset", out_en, 19'h7FFFF);
    chk("R12 sda released after reset", sda_drive_low, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R4 / R5 / R10: full read from index 0 with reset count 8, one extra byte
    rd(8'd0, 9, a);
    chk("R1 address ack", a, 1'b1);
    chk("R10 count byte reset", rbuf[0], 8'h08);
    chk("R6 byte0 reset", rbuf[1], 8'hB9);
    chk("R7 byte1 reset", rbuf[2], 8'hFF);
    chk("R7 byte2 reset", rbuf[3], 8'hFF);
    chk("R8 byte3 live pins", rbuf[4], 8'h5A);
    chk("R9 byte4 zero", rbuf[5], 8'h00);
    chk("R9 byte5 vendor", rbuf[6], 8'h0F);
    chk("R9 byte6 id", rbuf[7], 8'h78);
    chk("R10 byte7 value", rbuf[8], 8'h08);
    chk("R5 byte past count released", rbuf[9], 8'hFF);
    chk("R11 released after stop", sda_drive_low, 1'b0);

    // R2 / R6..R9 vector table
    for (int i = 0; i < 14; i++) begin
      wr1(VEC[i][23:16], VEC[i][15:8], a);
      chk("R2 data ack", a, 1'b1);
      rd(VEC[i][23:16], 1, a2);
      chk("R4 R6 R8 R9 readback", rbuf[1], VEC[i][7:0]);
      if (i == 3) chk("R7 out_en mid table", out_en, 19'h03CA5);
    end
    chk("R7 R6 out_en after table", out_en, 19'h5FFFF);

    // R10: shorter count, bits 7:5 dropped, R5 float after it
    wr1(8'd7, 8'hE3, a);
    rd(8'd5, 4, a);
    chk("R10 count byte programmed", rbuf[0], 8'h03);
    chk("R9 byte5 in short read", rbuf[1], 8'h0F);
    chk("R9 byte6 in short read", rbuf[2], 8'h78);
    chk("R10 byte7 masked", rbuf[3], 8'h03);
    chk("R5 float after short count", rbuf[4], 8'hFF);
    wr1(8'd7, 8'h08, a);

    // R3: byte beyond count is NACKed and not stored
    bus_start(); put_byte(ADR, a); put_byte(8'd1, a); put_byte(8'd1, a);
    put_byte(8'h11, a); put_byte(8'h22, a2); bus_stop();
    chk("R2 first data ack", a, 1'b1);
    chk("R3 excess byte nack", a2, 1'b0);
    rd(8'd1, 2, a);
    chk("R2 byte1 stored", rbuf[1], 8'h11);
    chk("R3 byte2 untouched", rbuf[2], 8'hFF);

    // R1: foreign address ignored
    bus_start(); put_byte(8'hC4, a); put_byte(8'd1, a2); put_byte(8'd1, a2);
    put_byte(8'h99, a2); bus_stop();
    chk("R1 foreign address nack", a, 1'b0);
    rd(8'd1, 1, a);
    chk("R1 foreign write no effect", rbuf[1], 8'h11);

    // R11: stop mid-write keeps completed bytes, aborts the rest
    bus_start(); put_byte(ADR, a); put_byte(8'd2, a); put_byte(8'd2, a);
    put_byte(8'h77, a); bus_stop();
    chk("R11 sda free after abort", sda_drive_low, 1'b0);
    rd(8'd2, 1, a);
    chk("R11 byte before stop stored", rbuf[1], 8'h77);

    // R1 strap sweep
    for (int k = 0; k < 9; k++) begin
      strap_hi = (k / 3 == 2) ? 2'b10 : ((k / 3 == 1) ? 2'b01 : 2'b00);
      strap_lo = (k % 3 == 2) ? 2'b10 : ((k % 3 == 1) ? 2'b01 : 2'b00);
      bus_start(); put_byte(SADR[k], a); bus_stop();
      chk("R1 strap address ack", a, 1'b1);
      bus_start(); put_byte(SADR[(k + 1) % 9], a); bus_stop();
      chk("R1 other address nack", a, 1'b0);
    end
    strap_hi = 2'b11; strap_lo = 2'b11;
    bus_start(); put_byte(8'hC4, a); bus_stop();
    chk("R1 code 11 as mid", a, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule